// File: doc/BRIEF.md
# Single-Bus Microstepped Processor Core

This block is a small processor in which every internal transfer travels over one shared 16-bit bus. The program counter, memory address register, memory data register, instruction register, a spare TEMP register, eight general registers, an ALU operand latch Y and an ALU result latch Z each have their own "drive the bus" and "capture from the bus" enables. A hardwired controller sequences those enables one micro-step per clock. Each instruction is a fixed chain of micro-steps: a common fetch, then a short execute chain for indirect load, indirect store, register move or an add/subtract/exclusive-or.

Memory sits outside the block behind a simple request port: an address, write data, read data, a read strobe, a write strobe and a completion input. The completion input may arrive after any number of cycles. The controller parks in the waiting step until it does.

Controller states and transitions: `ST_F_ADDR` (MAR takes PC) → `ST_F_WAIT` (read strobe, hold until completion) → `ST_F_LATCH` (IR takes MDR, PC steps). From `ST_F_LATCH` the fetched opcode selects the next state. A load goes to `ST_LD_ADDR` → `ST_LD_WAIT` → `ST_LD_WB`. A store goes to `ST_SD_ADDR` → `ST_SD_DATA` → `ST_SD_WAIT`. A move goes to `ST_MV`. An ALU opcode goes to `ST_AL_Y` → `ST_AL_Z` → `ST_AL_WB`. Halt goes to `ST_HALT`, which is terminal. Any other opcode returns to `ST_F_ADDR`. Every execute chain other than halt ends by returning to `ST_F_ADDR`.

Top module: `sbus_cpu`

## Requirements
- R1: While reset is low, mem_rd, mem_wr and halted are low. PC and all general registers reset to zero. The first memory request after reset is a read of address 0, visible in the second cycle after release.
- R2: Instruction word layout: bits 15:12 opcode, bits 11:9 destination register d, bits 8:6 source register s, bits 5:0 ignored. Opcodes: 0 no-op, 1 load, 2 store, 3 move, 4 add, 5 sub, 6 xor, 15 halt. Each instruction is fetched by one read at PC, and PC grows by 1 per fetch.
- R3: Load (opcode 1) sets Rd to the memory word at address Rs.
- R4: Store (opcode 2) writes Rd to memory address Rs, issuing exactly one write request per store.
- R5: Move (opcode 3) copies Rs into Rd.
- R6: Add, sub and xor (opcodes 4, 5, 6) set Rd to Rd+Rs, Rd−Rs or Rd^Rs, modulo 2^16. Rd and Rs may name the same register.
- R7: Halt (opcode 15) raises halted, which stays high. No further memory request is issued until reset.
- R8: Opcodes 7 to 14 and opcode 0 change no register and no memory word, and execution continues at the next word.
- R9: mem_rd and mem_wr are never high together. A raised strobe, its address and its write data stay unchanged until the cycle in which mem_mfc is sampled high.
- R10: Program results do not depend on memory latency. The controller holds its step while waiting for completion.
- R11: At most one source drives the internal bus in any cycle, and exactly one drives it whenever any register captures from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory address, taken from MAR |
| mem_wdata | output | 16 | Write data, taken from MDR |
| mem_rdata | input | 16 | Read data, captured into MDR on completion |
| mem_rd | output | 1 | Read request, held until completion |
| mem_wr | output | 1 | Write request, held until completion |
| mem_mfc | input | 1 | Memory function completed |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench runs the same arithmetic program twice: once with completion on the first waiting cycle, and once with random latency of up to several cycles. A controller that advances without waiting, or that captures read data on the wrong edge, produces different stored sums and differences between the two runs. Rd equal to Rs and a subtraction that wraps below zero are exercised. A design that latched operand B into Y, or that lost the borrow, would store a wrong word. An undefined opcode that targets a live register is placed just before that register is copied, so a decoder that treats it as a load or move corrupts the copy. A program that halts on its first word checks that a halted core issues no further reads.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int OPC_W   = 4;
    localparam int RIDX_W  = 3;
    localparam int NUM_GPR = 1 << RIDX_W;

    localparam logic [OPC_W-1:0] OPC_NOP   = 4'd0;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
    localparam logic [OPC_W-1:0] OPC_MOVE  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd4;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_XOR   = 4'd6;
    localparam logic [OPC_W-1:0] OPC_HALT  = 4'd15;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_XOR = 2'd2
    } alu_op_e;

    typedef enum logic [3:0] {
        ST_F_ADDR,
        ST_F_WAIT,
        ST_F_LATCH,
        ST_LD_ADDR,
        ST_LD_WAIT,
        ST_LD_WB,
        ST_SD_ADDR,
        ST_SD_DATA,
        ST_SD_WAIT,
        ST_MV,
        ST_AL_Y,
        ST_AL_Z,
        ST_AL_WB,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic              pc_out;
        logic              mdr_out;
        logic              z_out;
        logic              temp_out;
        logic              gpr_out;
        logic [RIDX_W-1:0] gpr_out_idx;
        logic              pc_inc;
        logic              mar_in;
        logic              mdr_in;
        logic              ir_in;
        logic              y_in;
        logic              z_in;
        logic              temp_in;
        logic              gpr_in;
        logic [RIDX_W-1:0] gpr_in_idx;
        alu_op_e           alu_op;
        logic              mem_rd;
        logic              mem_wr;
    } ctl_t;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] res
);
    logic              invert_b;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;

    always_comb begin
        invert_b = (op == ALU_SUB);
        b_eff    = opb ^ {DATA_W{invert_b}};
        // subtraction uses the carry-in as the +1 of two's complement
        sum      = opa + b_eff + DATA_W'(invert_b);
        unique case (op)
            ALU_XOR: res = opa ^ opb;
            default: res = sum;
        endcase
    end
endmodule

// File: rtl/sbus_gpr.sv
module sbus_gpr
    import sbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic [RIDX_W-1:0] out_idx,
    input  logic              in_en,
    input  logic [RIDX_W-1:0] in_idx,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_drive
);
    logic [NUM_GPR-1:0] sel_out;
    logic [NUM_GPR-1:0] sel_in;
    logic [DATA_W-1:0]  regs [NUM_GPR];

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
        assign sel_out[g] = out_en && (out_idx == RIDX_W'(g));
        assign sel_in[g]  = in_en  && (in_idx  == RIDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (sel_in[g]) begin
                regs[g] <= bus_in;
            end
        end
    end

    always_comb begin
        bus_drive = '0;
        for (int i = 0; i < NUM_GPR; i++) begin
            if (sel_out[i]) begin
                bus_drive = bus_drive | regs[i];
            end
        end
    end
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  fetch_opc,
    input  logic [OPC_W-1:0]  ir_opc,
    input  logic [RIDX_W-1:0] ir_rd,
    input  logic [RIDX_W-1:0] ir_rs,
    input  logic              mem_mfc,
    output ctl_t              ctl,
    output logic              halted
);
    state_e state_q;
    state_e state_d;
    logic   waiting;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_F_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_F_ADDR:  state_d = ST_F_WAIT;
            ST_F_WAIT:  if (mem_mfc) state_d = ST_F_LATCH;
            ST_F_LATCH: begin
                case (fetch_opc)
                    OPC_LOAD:                  state_d = ST_LD_ADDR;
                    OPC_STORE:                 state_d = ST_SD_ADDR;
                    OPC_MOVE:                  state_d = ST_MV;
                    OPC_ADD, OPC_SUB, OPC_XOR: state_d = ST_AL_Y;
                    OPC_HALT:                  state_d = ST_HALT;
                    default:                   state_d = ST_F_ADDR;
                endcase
            end
            ST_LD_ADDR: state_d = ST_LD_WAIT;
            ST_LD_WAIT: if (mem_mfc) state_d = ST_LD_WB;
            ST_LD_WB:   state_d = ST_F_ADDR;
            ST_SD_ADDR: state_d = ST_SD_DATA;
            ST_SD_DATA: state_d = ST_SD_WAIT;
            ST_SD_WAIT: if (mem_mfc) state_d = ST_F_ADDR;
            ST_MV:      state_d = ST_F_ADDR;
            ST_AL_Y:    state_d = ST_AL_Z;
            ST_AL_Z:    state_d = ST_AL_WB;
            ST_AL_WB:   state_d = ST_F_ADDR;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_F_ADDR;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_F_ADDR: begin
                ctl.pc_out = 1'b1;
                ctl.mar_in = 1'b1;
            end
            ST_F_WAIT:  ctl.mem_rd = 1'b1;
            ST_F_LATCH: begin
                ctl.mdr_out = 1'b1;
                ctl.ir_in   = 1'b1;
                ctl.pc_inc  = 1'b1;
            end
            ST_LD_ADDR, ST_SD_ADDR: begin
                ctl.gpr_out     = 1'b1;
                ctl.gpr_out_idx = ir_rs;
                ctl.mar_in      = 1'b1;
            end
            ST_LD_WAIT: ctl.mem_rd = 1'b1;
            ST_LD_WB: begin
                ctl.mdr_out    = 1'b1;
                ctl.gpr_in     = 1'b1;
                ctl.gpr_in_idx = ir_rd;
            end
            ST_SD_DATA: begin
                ctl.gpr_out     = 1'b1;
                ctl.gpr_out_idx = ir_rd;
                ctl.mdr_in      = 1'b1;
            end
            ST_SD_WAIT: ctl.mem_wr = 1'b1;
            ST_MV: begin
                ctl.gpr_out     = 1'b1;
                ctl.gpr_out_idx = ir_rs;
                ctl.gpr_in      = 1'b1;
                ctl.gpr_in_idx  = ir_rd;
            end
            ST_AL_Y: begin
                ctl.gpr_out     = 1'b1;
                ctl.gpr_out_idx = ir_rd;
                ctl.y_in        = 1'b1;
            end
            ST_AL_Z: begin
                ctl.gpr_out     = 1'b1;
                ctl.gpr_out_idx = ir_rs;
                ctl.z_in        = 1'b1;
                case (ir_opc)
                    OPC_SUB: ctl.alu_op = ALU_SUB;
                    OPC_XOR: ctl.alu_op = ALU_XOR;
                    default: ctl.alu_op = ALU_ADD;
                endcase
            end
            ST_AL_WB: begin
                ctl.z_out      = 1'b1;
                ctl.gpr_in     = 1'b1;
                ctl.gpr_in_idx = ir_rd;
            end
            default: ;
        endcase
    end

    assign halted  = (state_q == ST_HALT);
    assign waiting = (state_q == ST_F_WAIT) || (state_q == ST_LD_WAIT) ||
                     (state_q == ST_SD_WAIT);

    // R10: a waiting step is held until completion arrives
    assert_wait_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !mem_mfc) |=> (state_q == $past(state_q)));

    // R7: once halted, stay halted with no memory request
    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !ctl.mem_rd && !ctl.mem_wr));
endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
    import sbus_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PC_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_mfc,
    output logic              halted
);
    localparam int OPC_LSB  = DATA_W - OPC_W;
    localparam int RD_LSB   = OPC_LSB - RIDX_W;
    localparam int RS_LSB   = RD_LSB - RIDX_W;
    localparam int NSRC     = 5;
    localparam int SRC_PC   = 0;
    localparam int SRC_MDR  = 1;
    localparam int SRC_Z    = 2;
    localparam int SRC_TEMP = 3;
    localparam int SRC_GPR  = 4;

    ctl_t              ctl;
    logic [DATA_W-1:0] pc_q, mar_q, mdr_q, ir_q, temp_q, y_q, z_q;
    logic [DATA_W-1:0] bus, gpr_drv, alu_res;
    logic [NSRC-1:0]   drv_en;
    logic [DATA_W-1:0] src_val [NSRC];
    logic              any_capture;
    logic              ir_unused;

    assign drv_en = {ctl.gpr_out, ctl.temp_out, ctl.z_out, ctl.mdr_out, ctl.pc_out};

    always_comb begin
        src_val[SRC_PC]   = pc_q;
        src_val[SRC_MDR]  = mdr_q;
        src_val[SRC_Z]    = z_q;
        src_val[SRC_TEMP] = temp_q;
        src_val[SRC_GPR]  = gpr_drv;
    end

    // released sources contribute zero; the single enabled one owns the bus
    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (drv_en[i]) begin
                bus = bus | src_val[i];
            end
        end
    end

    sbus_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_opc (mdr_q[DATA_W-1:OPC_LSB]),
        .ir_opc    (ir_q[DATA_W-1:OPC_LSB]),
        .ir_rd     (ir_q[OPC_LSB-1:RD_LSB]),
        .ir_rs     (ir_q[RD_LSB-1:RS_LSB]),
        .mem_mfc   (mem_mfc),
        .ctl       (ctl),
        .halted    (halted)
    );

    sbus_gpr #(.DATA_W(DATA_W)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (ctl.gpr_out),
        .out_idx   (ctl.gpr_out_idx),
        .in_en     (ctl.gpr_in),
        .in_idx    (ctl.gpr_in_idx),
        .bus_in    (bus),
        .bus_drive (gpr_drv)
    );

    sbus_alu #(.DATA_W(DATA_W)) u_alu (
        .opa (y_q),
        .opb (bus),
        .op  (ctl.alu_op),
        .res (alu_res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mar_q  <= '0;
            mdr_q  <= '0;
            ir_q   <= '0;
            temp_q <= '0;
            y_q    <= '0;
            z_q    <= '0;
        end else begin
            if (ctl.pc_inc)  pc_q   <= pc_q + DATA_W'(PC_STEP);
            if (ctl.mar_in)  mar_q  <= bus;
            if (ctl.ir_in)   ir_q   <= bus;
            if (ctl.temp_in) temp_q <= bus;
            if (ctl.y_in)    y_q    <= bus;
            if (ctl.z_in)    z_q    <= alu_res;
            if (ctl.mdr_in) begin
                mdr_q <= bus;
            end else if (ctl.mem_rd && mem_mfc) begin
                mdr_q <= mem_rdata;
            end
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign ir_unused = ^ir_q[RS_LSB-1:0];

    assign any_capture = ctl.mar_in || ctl.mdr_in || ctl.ir_in || ctl.y_in ||
                         ctl.z_in || ctl.temp_in || ctl.gpr_in;

    // R11: bus ownership
    assert_bus_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));
    assert_bus_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_capture |-> ($countones(drv_en) == 1));

    // R9: strobes exclusive and held with stable address and data
    assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_mfc) |=> (mem_rd && $stable(mem_addr)));
    assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_mfc) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R2: PC steps once per instruction latch
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ir_in |=> (pc_q == $past(pc_q) + DATA_W'(PC_STEP)));
endmodule

// File: tb/sbus_cpu_test.sv
module sbus_cpu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_mfc;
    logic        halted;

    int checks = 0;
    int errors = 0;

    logic [15:0] img [256];
    logic [15:0] mem [256];
    int          rd_count, wr_count, excl_err, hold_err;
    logic [15:0] last_rd_addr, last_wr_addr, req_addr;
    int          max_lat = 0;
    int          cur_lat, wait_cnt;
    logic        pending;

    always #2 clk = ~clk;

    sbus_cpu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_mfc   (mem_mfc),
        .halted    (halted)
    );

    // behavioural memory, 256 words, address bits above 7 ignored
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = img[i];
            mem_mfc = 1'b0; mem_rdata = '0; pending = 1'b0; wait_cnt = 0;
            rd_count = 0; wr_count = 0; excl_err = 0; hold_err = 0;
            last_rd_addr = '0; last_wr_addr = '0;
        end else if (mem_mfc) begin
            mem_mfc = 1'b0; pending = 1'b0; wait_cnt = 0;
        end else if (mem_rd || mem_wr) begin
            if (mem_rd && mem_wr) excl_err++;
            if (!pending) begin
                pending  = 1'b1;
                req_addr = mem_addr;
                cur_lat  = $urandom_range(max_lat, 0);
                wait_cnt = 0;
            end else if (mem_addr !== req_addr) begin
                hold_err++;
            end
            if (wait_cnt >= cur_lat) begin
                mem_mfc = 1'b1;
                if (mem_rd) begin
                    mem_rdata = mem[mem_addr[7:0]];
                    rd_count++;
                    last_rd_addr = mem_addr;
                end else begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_count++;
                    last_wr_addr = mem_addr;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int d, input int s, input int x);
        return {op[3:0], d[2:0], s[2:0], x[5:0]};
    endfunction

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    endtask

    task automatic start(input int lat);
        rst_n   = 1'b0;
        max_lat = lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input int limit);
        for (int n = 0; n < limit && !halted; n++) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_img();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "mem_rd in reset", 16'(mem_rd), 16'd0);
        check("R1", "mem_wr in reset", 16'(mem_wr), 16'd0);
        check("R1", "halted in reset", 16'(halted), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "first read strobe", 16'(mem_rd), 16'd1);
        check("R1", "first read address", mem_addr, 16'h0000);
    endtask

    // load, move, add, sub, xor, store at a chosen memory latency
    task automatic t_arith(input int lat);
        logic [15:0] a = 16'h1234;
        logic [15:0] b = 16'h0FF0;
        int          rd_before;
        clear_img();
        img[0]  = enc(1, 1, 0, 6'h20);
        img[1]  = enc(1, 2, 1, 0);
        img[2]  = enc(3, 3, 1, 0);
        img[3]  = enc(4, 3, 2, 0);
        img[4]  = enc(1, 4, 3, 0);
        img[5]  = enc(4, 3, 2, 0);
        img[6]  = enc(1, 5, 3, 0);
        img[7]  = enc(3, 6, 4, 0);
        img[8]  = enc(4, 6, 5, 0);
        img[9]  = enc(3, 7, 4, 0);
        img[10] = enc(5, 7, 5, 0);
        img[11] = enc(6, 4, 5, 0);
        img[12] = enc(4, 3, 2, 0);
        img[13] = enc(2, 6, 3, 0);
        img[14] = enc(4, 3, 2, 0);
        img[15] = enc(2, 7, 3, 0);
        img[16] = enc(4, 3, 2, 0);
        img[17] = enc(2, 4, 3, 0);
        img[18] = enc(15, 0, 0, 0);
        img[8'h20] = 16'h0001;
        img[8'h21] = a;
        img[8'h22] = b;
        start(lat);
        wait_halt(3000);
        check("R7", "halted after program", 16'(halted), 16'd1);
        check("R6 R11 R10", "sum stored", mem[8'h23], a + b);
        check("R6 R11 R10", "difference stored", mem[8'h24], a - b);
        check("R6 R3 R5", "xor stored", mem[8'h25], a ^ b);
        check("R2", "read count", 16'(rd_count), 16'd23);
        check("R2", "last fetch address", last_rd_addr, 16'd18);
        check("R4", "write count", 16'(wr_count), 16'd3);
        check("R4", "last write address", last_wr_addr, 16'h1225);
        check("R9", "rd and wr together", 16'(excl_err), 16'd0);
        check("R9", "address moved while waiting", 16'(hold_err), 16'd0);
        rd_before = rd_count;
        repeat (40) @(negedge clk);
        check("R7", "reads after halt", 16'(rd_count), 16'(rd_before));
        check("R7", "halted stays high", 16'(halted), 16'd1);
    endtask

    // undefined opcode and no-op, same-register xor, wrapping subtract
    task automatic t_move_nop();
        logic [15:0] c = 16'hBEEF;
        clear_img();
        img[0]  = enc(1, 1, 0, 6'h20);
        img[1]  = enc(1, 2, 1, 0);
        img[2]  = enc(3, 3, 1, 0);
        img[3]  = enc(4, 3, 2, 0);
        img[4]  = enc(1, 4, 3, 0);
        img[5]  = enc(9, 4, 4, 6'h3F);
        img[6]  = enc(0, 4, 1, 0);
        img[7]  = enc(3, 5, 4, 0);
        img[8]  = enc(6, 4, 4, 0);
        img[9]  = enc(5, 6, 2, 0);
        img[10] = enc(4, 3, 2, 0);
        img[11] = enc(2, 5, 3, 0);
        img[12] = enc(4, 3, 2, 0);
        img[13] = enc(2, 4, 3, 0);
        img[14] = enc(4, 3, 2, 0);
        img[15] = enc(2, 6, 3, 0);
        img[16] = enc(15, 0, 0, 0);
        img[8'h20] = 16'h0001;
        img[8'h21] = c;
        img[8'h23] = 16'h5555;
        start(2);
        wait_halt(3000);
        check("R8 R5", "register copied past undefined opcode", mem[8'h22], c);
        check("R6", "xor of register with itself", mem[8'h23], 16'h0000);
        check("R6", "subtract wraps below zero", mem[8'h24], 16'hFFFF);
        check("R8", "read count with no-ops", 16'(rd_count), 16'd20);
        check("R8", "write count with no-ops", 16'(wr_count), 16'd3);
    endtask

    task automatic t_halt_first();
        clear_img();
        img[0] = enc(15, 2, 3, 0);
        img[1] = enc(2, 0, 0, 0);
        start(1);
        repeat (60) @(negedge clk);
        check("R7", "halted on first word", 16'(halted), 16'd1);
        check("R7", "only the halt was fetched", 16'(rd_count), 16'd1);
        check("R7", "no write after halt", 16'(wr_count), 16'd0);
    endtask

    initial begin
        t_reset();
        t_arith(0);
        t_arith(5);
        t_move_nop();
        t_halt_first();
        finish_run();
    end
endmodule